// File: doc/BRIEF.md
# Protected Memory Window Access Gate

This block sits in the path of every memory access and decides whether the access may reach the memory set aside for the processor's management mode. There are three such windows. The first is a fixed window in low memory. The second is a fixed window just below the 4 GiB boundary. The third is a top window whose base and size firmware programs. An access that hits any window is allowed when the processor reports that it is in management mode, or when firmware has opened the windows. Otherwise the access is blocked: a read gets an all-ones substitute value, and a write is suppressed.

Firmware first loads the top window base and size. It then clears the open bit and sets the lock bit. After that, the top window registers are frozen, and the windows can no longer be reopened before the next reset. The hit decode is purely combinational from the access address. The control registers update on the clock edge.

Top module: `pmw_gate`

## Requirements
- R1: An address in 0x000A0000..0x000BFFFF, both ends included, counts as a window hit. 0x0009FFFF and 0x000C0000 do not.
- R2: An address in 0xFEDA0000..0xFEDBFFFF, both ends included, counts as a window hit. 0xFED9FFFF and 0xFEDC0000 do not.
- R3: The top window hits when base <= addr < base + size. A size of zero disables the top window. Base is written with cfg_sel = 1 and size with cfg_sel = 2.
- R4: When a valid read that hits a window is blocked, rd_subst_data is all ones. In every other case rd_subst_data is zero.
- R5: A valid write that hits a window while it is blocked raises wr_suppress and drops acc_allow. wr_suppress stays low when acc_valid is low.
- R6: While mgmt_mode is high, acc_allow is high and wr_suppress is low for every address, whatever the state of the open bit.
- R7: With the open bit set (cfg_sel = 0, wdata bit 0), window hits are allowed outside management mode.
- R8: The lock bit (cfg_sel = 0, wdata bit 1) is write-once and only reset clears it. While it is set, the open bit can be cleared but never set.
- R9: While the lock bit is set, writes to the top window base and size have no effect.
- R10: After reset, the open bit and the lock bit are 0, the top base is TOP_BASE_RST and the top size is TOP_SIZE_RST.
- R11: acc_allow, wr_suppress and rd_subst_data follow the address and mgmt_mode in the same cycle. A register write shows only after the next rising clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | 1 for a write, 0 for a read |
| acc_addr | input | 32 | Physical address of the access |
| mgmt_mode | input | 1 | Processor is in management mode |
| cfg_wr_en | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | 0 control, 1 top base, 2 top size |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_open | output | 1 | Current open bit |
| cfg_lock | output | 1 | Current lock bit |
| top_base | output | 32 | Current top window base |
| top_size | output | 32 | Current top window size |
| win_hit | output | 1 | Address falls in any window |
| acc_allow | output | 1 | Access may reach memory |
| wr_suppress | output | 1 | Drop this write |
| rd_subst_data | output | DATA_W | All ones for a blocked read, else zero |

## Verification
The hardest state to reach is a locked register set in which the open bit was still high when the lock was applied. Reaching it takes a specific order of writes: open, then lock together with open, then clear open, then try to set open again. The bench drives exactly that order and checks at each step that open cannot come back. It then issues top-window writes while locked and reads back the unchanged base and size. Finally, a mid-run reset must release the lock.

// File: rtl/pmw_pkg.sv
package pmw_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned NUM_WIN = 3;

  typedef enum logic [1:0] {
    CFG_CTRL = 2'd0,
    CFG_BASE = 2'd1,
    CFG_SIZE = 2'd2
  } cfg_sel_e;

  localparam logic [ADDR_W-1:0] LOW_BASE  = 32'h000A_0000;
  localparam logic [ADDR_W-1:0] LOW_SIZE  = 32'h0002_0000;
  localparam logic [ADDR_W-1:0] HIGH_BASE = 32'hFEDA_0000;
  localparam logic [ADDR_W-1:0] HIGH_SIZE = 32'h0002_0000;

  // Half-open interval test written with a subtraction so base+size never overflows.
  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input logic [ADDR_W-1:0] size);
    return (size != '0) && (addr >= base) && ((addr - base) < size);
  endfunction
endpackage

// File: rtl/pmw_cfg_regs.sv
module pmw_cfg_regs
  import pmw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] TOP_BASE_RST = 32'h7F00_0000,
  parameter logic [ADDR_W-1:0] TOP_SIZE_RST = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        sel,
  input  logic [ADDR_W-1:0] wdata,
  output logic              open_q,
  output logic              lock_q,
  output logic [ADDR_W-1:0] base_q,
  output logic [ADDR_W-1:0] size_q
);
  cfg_sel_e sel_e;
  logic     ctrl_wr, base_wr, size_wr;
  logic     open_d, lock_d;

  assign sel_e   = cfg_sel_e'(sel);
  assign ctrl_wr = wr_en && (sel_e == CFG_CTRL);
  assign base_wr = wr_en && (sel_e == CFG_BASE) && !lock_q;
  assign size_wr = wr_en && (sel_e == CFG_SIZE) && !lock_q;

  always_comb begin
    open_d = open_q;
    lock_d = lock_q;
    if (ctrl_wr) begin
      // once locked, open may only be cleared
      open_d = lock_q ? (open_q & wdata[0]) : wdata[0];
      lock_d = lock_q | wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      lock_q <= 1'b0;
      base_q <= TOP_BASE_RST;
      size_q <= TOP_SIZE_RST;
    end else begin
      open_q <= open_d;
      lock_q <= lock_d;
      if (base_wr) base_q <= wdata;
      if (size_wr) size_q <= wdata;
    end
  end

  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  a_r8_no_reopen: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !open_q) |=> !open_q);
  a_r9_base_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(base_q));
  a_r9_size_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> $stable(size_q));
endmodule

// File: rtl/pmw_win_match.sv
module pmw_win_match
  import pmw_pkg::*;
#(
  parameter logic [ADDR_W-1:0] WIN_BASE     = LOW_BASE,
  parameter logic [ADDR_W-1:0] WIN_SIZE     = LOW_SIZE,
  parameter bit                PROGRAMMABLE = 1'b0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] prog_base,
  input  logic [ADDR_W-1:0] prog_size,
  output logic              hit
);
  generate
    if (PROGRAMMABLE) begin : g_prog
      assign hit = in_window(addr, prog_base, prog_size);
    end else begin : g_fixed
      logic [2*ADDR_W-1:0] unused_prog;
      assign unused_prog = {prog_base, prog_size};
      assign hit = in_window(addr, WIN_BASE, WIN_SIZE);
    end
  endgenerate
endmodule

// File: rtl/pmw_gate.sv
module pmw_gate
  import pmw_pkg::*;
#(
  parameter int unsigned       DATA_W       = 32,
  parameter logic [ADDR_W-1:0] TOP_BASE_RST = 32'h7F00_0000,
  parameter logic [ADDR_W-1:0] TOP_SIZE_RST = 32'h0080_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              mgmt_mode,
  input  logic              cfg_wr_en,
  input  logic [1:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  output logic              cfg_open,
  output logic              cfg_lock,
  output logic [ADDR_W-1:0] top_base,
  output logic [ADDR_W-1:0] top_size,
  output logic              win_hit,
  output logic              acc_allow,
  output logic              wr_suppress,
  output logic [DATA_W-1:0] rd_subst_data
);
  logic [NUM_WIN-1:0] hits;
  logic               blocked;

  pmw_cfg_regs #(.TOP_BASE_RST(TOP_BASE_RST), .TOP_SIZE_RST(TOP_SIZE_RST)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr_en),
    .sel    (cfg_sel),
    .wdata  (cfg_wdata),
    .open_q (cfg_open),
    .lock_q (cfg_lock),
    .base_q (top_base),
    .size_q (top_size)
  );

  // window 0: low fixed, 1: high fixed, 2: programmable top
  for (genvar gi = 0; gi < NUM_WIN; gi++) begin : g_win
    pmw_win_match #(
      .WIN_BASE     ((gi == 0) ? LOW_BASE : HIGH_BASE),
      .WIN_SIZE     ((gi == 0) ? LOW_SIZE : HIGH_SIZE),
      .PROGRAMMABLE (gi == 2)
    ) u_match (
      .addr      (acc_addr),
      .prog_base (top_base),
      .prog_size (top_size),
      .hit       (hits[gi])
    );
  end

  assign win_hit       = |hits;
  assign blocked       = win_hit && !mgmt_mode && !cfg_open;
  assign acc_allow     = !blocked;
  assign wr_suppress   = acc_valid && acc_write && blocked;
  assign rd_subst_data = (acc_valid && !acc_write && blocked) ? {DATA_W{1'b1}} : '0;

  a_r5_suppress_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_suppress |-> (win_hit && !mgmt_mode && !cfg_open && acc_valid));
  a_r4_fill_only_blocked_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_subst_data != '0) |-> (acc_valid && !acc_write && win_hit && !mgmt_mode));
  a_r6_mgmt_passes: assert property (@(posedge clk) disable iff (!rst_n)
    mgmt_mode |-> (acc_allow && !wr_suppress && rd_subst_data == '0));
  a_r7_open_passes: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open |-> acc_allow);
endmodule

// File: tb/pmw_gate_tb.sv
module pmw_gate_tb;
  localparam int DW = 32;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b1, acc_write = 1'b0, mgmt_mode = 1'b0;
  logic [31:0] acc_addr = '0;
  logic        cfg_wr_en = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [31:0] cfg_wdata = '0;
  logic        cfg_open, cfg_lock, win_hit, acc_allow, wr_suppress;
  logic [31:0] top_base, top_size;
  logic [DW-1:0] rd_subst_data;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  pmw_gate #(.DATA_W(DW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive an access and check the combinational outputs against the rules.
  task automatic access(input string req, input logic m, input logic w,
                        input logic [31:0] a, input logic exp_allow);
    mgmt_mode = m; acc_write = w; acc_addr = a;
    #1;
    chk({req, " allow"}, {31'b0, acc_allow}, {31'b0, exp_allow});
    chk({req, " suppress"}, {31'b0, wr_suppress}, {31'b0, w & ~exp_allow});
    chk({req, " subst"}, rd_subst_data, (!w && !exp_allow) ? ONES : 32'h0);
  endtask

  task automatic cfg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_wr_en = 1'b0;
  endtask

  typedef struct packed {
    logic [7:0]  req;
    logic        m;
    logic        w;
    logic [31:0] addr;
    logic        allow;
  } vec_t;

  // open=0, top window 0x7F000000..0x7F7FFFFF (reset values)
  localparam vec_t VECS [15] = '{
    '{8'd1, 1'b0, 1'b0, 32'h0009_FFFF, 1'b1},  // R1 below
    '{8'd1, 1'b0, 1'b0, 32'h000A_0000, 1'b0},  // R1 first
    '{8'd1, 1'b0, 1'b0, 32'h000B_FFFF, 1'b0},  // R1 last
    '{8'd1, 1'b0, 1'b0, 32'h000C_0000, 1'b1},  // R1 above
    '{8'd2, 1'b0, 1'b0, 32'hFED9_FFFF, 1'b1},  // R2 below
    '{8'd2, 1'b0, 1'b0, 32'hFEDA_0000, 1'b0},  // R2 first
    '{8'd2, 1'b0, 1'b0, 32'hFEDB_FFFF, 1'b0},  // R2 last
    '{8'd2, 1'b0, 1'b0, 32'hFEDC_0000, 1'b1},  // R2 above
    '{8'd3, 1'b0, 1'b0, 32'h7EFF_FFFF, 1'b1},  // R3 below
    '{8'd3, 1'b0, 1'b0, 32'h7F00_0000, 1'b0},  // R3 base
    '{8'd3, 1'b0, 1'b0, 32'h7F7F_FFFF, 1'b0},  // R3 last
    '{8'd3, 1'b0, 1'b0, 32'h7F80_0000, 1'b1},  // R3 end
    '{8'd6, 1'b1, 1'b0, 32'h000A_0000, 1'b1},  // R6 mgmt read
    '{8'd6, 1'b1, 1'b1, 32'hFEDA_0010, 1'b1},  // R6 mgmt write
    '{8'd5, 1'b0, 1'b1, 32'h7F00_0100, 1'b0}   // R5 blocked write
  };

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    // R10 reset state (while held)
    chk("R10 open", {31'b0, cfg_open}, 32'h0);
    chk("R10 lock", {31'b0, cfg_lock}, 32'h0);
    chk("R10 base", top_base, 32'h7F00_0000);
    chk("R10 size", top_size, 32'h0080_0000);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);

    foreach (VECS[i]) begin
      access($sformatf("R%0d vec%0d", VECS[i].req, i), VECS[i].m, VECS[i].w,
             VECS[i].addr, VECS[i].allow);
    end

    // R5 no suppress without a valid access
    acc_valid = 1'b0; acc_write = 1'b1; mgmt_mode = 1'b0; acc_addr = 32'h000A_0000; #1;
    chk("R5 idle suppress", {31'b0, wr_suppress}, 32'h0);
    acc_valid = 1'b1;

    // R3 reprogram top window; R11 update after the edge only
    @(negedge clk);
    cfg_wr_en = 1'b1; cfg_sel = 2'd1; cfg_wdata = 32'h1000_0000; #1;
    chk("R11 base before edge", top_base, 32'h7F00_0000);
    @(negedge clk); cfg_wr_en = 1'b0; #1;
    chk("R11 base after edge", top_base, 32'h1000_0000);
    cfg_write(2'd2, 32'h0000_1000);
    access("R3 new last", 1'b0, 1'b0, 32'h1000_0FFF, 1'b0);
    access("R3 new end", 1'b0, 1'b0, 32'h1000_1000, 1'b1);
    access("R3 old region", 1'b0, 1'b0, 32'h7F00_0000, 1'b1);
    cfg_write(2'd2, 32'h0);
    access("R3 zero size", 1'b0, 1'b0, 32'h1000_0000, 1'b1);
    // R11 same-cycle response to mgmt_mode
    access("R11 blocked", 1'b0, 1'b1, 32'hFEDA_0000, 1'b0);
    access("R11 mgmt flip", 1'b1, 1'b1, 32'hFEDA_0000, 1'b1);

    // R7 open
    cfg_write(2'd0, 32'h1); #1;
    chk("R7 open set", {31'b0, cfg_open}, 32'h1);
    access("R7 open read", 1'b0, 1'b0, 32'h000A_0000, 1'b1);
    access("R7 open write", 1'b0, 1'b1, 32'hFEDB_0000, 1'b1);

    // R8 lock with open still high, then clear, then try to reopen
    cfg_write(2'd0, 32'h3); #1;
    chk("R8 lock set", {31'b0, cfg_lock}, 32'h1);
    chk("R8 open kept", {31'b0, cfg_open}, 32'h1);
    cfg_write(2'd0, 32'h2); #1;
    chk("R8 open cleared", {31'b0, cfg_open}, 32'h0);
    cfg_write(2'd0, 32'h1); #1;
    chk("R8 no reopen", {31'b0, cfg_open}, 32'h0);
    chk("R8 lock kept", {31'b0, cfg_lock}, 32'h1);
    access("R8 still blocked", 1'b0, 1'b0, 32'h000A_0000, 1'b0);

    // R9 top window frozen
    cfg_write(2'd1, 32'h2000_0000);
    cfg_write(2'd2, 32'h0000_4000); #1;
    chk("R9 base frozen", top_base, 32'h1000_0000);
    chk("R9 size frozen", top_size, 32'h0);

    // R8 reset releases lock
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R8 lock after reset", {31'b0, cfg_lock}, 32'h0);
    chk("R10 base after reset", top_base, 32'h7F00_0000);
    @(negedge clk); rst_n = 1'b1;
    cfg_write(2'd0, 32'h1); #1;
    chk("R8 open after reset", {31'b0, cfg_open}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule